// File: doc/BRIEF.md
# Segmented Vector Load Address Sequencer

This block walks through one predicated vector load and works out, for each element and each field of a segment, the byte address to read. It issues those reads one at a time on a valid/ready request channel. When each read completes, it routes the returned word to destination register `rd + j` at element position `i`.

Three addressing forms are supported:
- **Unit stride:** the stride is the element size.
- **Constant stride:** the stride comes from a scalar register value.
- **Indexed:** selected by the offset register's vectorised flag, with no separate opcode bit. Each element's offset is read from a per-element offset vector.

A segment of `seglen + 1` fields is read for each element. The fields interleave by the stride inside each element.

An issuing pipeline pulses `start` with the whole configuration on its inputs. The block latches that configuration. It then streams reads element by element, skipping elements that the predicate masks off, and pulses `done` at the end. There is no cache, alignment or fault handling; the memory side simply answers each request once.

Top module: `seg_load_agen`

## Requirements
- R1: With `unit_stride`=1, the stride in bytes is the element size given by `elem_size` (code 0,1,2,3 → 1,2,4,8 bytes).
- R2: With `unit_stride`=0, the stride is `stride_val` as latched at start.
- R3: When `idx_vec`=0, field j of element i is read from `base + i*(seglen+1)*stride + j*stride`.
- R4: When `idx_vec`=1, field j of element i is read from `base + idx[i] + j*stride`, where idx[i] is `idx_flat[i*AW +: AW]`.
- R5: Each response word is written through `wr_data` to register `rd + j` (modulo 2^REGW), element `i`, in the same cycle that `rsp_valid` is high.
- R6: With `pred_en`=1, element i (i < vl) is active only when `pred_mask[i] ^ pred_inv` is 1.
- R7: With `pred_en`=0, every element i < vl is active, whatever the mask holds.
- R8: An inactive element produces no request and no write.
- R9: Requests go out element-major and then by field, with at most one outstanding. A request with `req_ready` low stays valid with an unchanged address, and the next request is raised only after the previous response.
- R10: `done` is a single-cycle pulse after the last response has been written. With vl = 0 it is high in the cycle right after the one in which `start` was sampled.
- R11: After reset the block is idle with no request, write or `done`. A `start` seen while `busy` is high is ignored, and the inputs are read only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; accepted only when idle |
| base_addr | input | AW | Scalar base byte address |
| stride_val | input | AW | Scalar stride for constant-stride mode |
| elem_size | input | 2 | Element size code (bytes = 1 << code) |
| unit_stride | input | 1 | 1 = stride is element size |
| idx_vec | input | 1 | Offset register is vectorised: indexed load |
| idx_flat | input | MAX_VL*AW | Per-element byte offsets, element i at bits i*AW |
| seglen | input | SEGW | Fields per element minus one |
| vl | input | VLW | Vector length (0..MAX_VL) |
| rd | input | REGW | First destination register |
| pred_en | input | 1 | Predication enabled for the destination |
| pred_inv | input | 1 | Invert the mask sense |
| pred_mask | input | MAX_VL | Per-element predicate bits |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | AW | Read byte address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | DW | Returned word |
| wr_en | output | 1 | Destination write strobe |
| wr_reg | output | REGW | Destination register number |
| wr_elem | output | EW | Destination element position |
| wr_data | output | DW | Destination write data |

## Verification
On every cycle, the assertions check the channel discipline:
- a stalled request holds its address;
- an accepted request is followed by a gap until the next one;
- writes happen only with a response, inside vl, to an active element, and within `rd..rd+seglen`;
- `done` is a one-cycle pulse seen only when idle.

Only the bench's sweeps can show that the address arithmetic is right in each mode, element size and segment length, and that the order of requests matches the element-major walk. The same holds for the exact cycle of `done` on an empty load and for a second `start` during a run leaving the sequence untouched.

// File: rtl/sla_pkg.sv
package sla_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } sla_state_e;

    // byte count for an element size code
    function automatic logic [3:0] elem_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sla_active.sv
// Finds the lowest active element at or above the cursor.
module sla_active #(
    parameter int MAX_VL = 8,
    parameter int VLW    = 4,
    parameter int EW     = 3
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic              pred_en,
    input  logic              pred_inv,
    input  logic [VLW-1:0]    vl,
    input  logic [VLW-1:0]    cursor,
    output logic              found,
    output logic [EW-1:0]     first
);

    logic [MAX_VL-1:0] act;

    for (genvar g = 0; g < MAX_VL; g++) begin : g_act
        assign act[g] = (VLW'(g) < vl) && (!pred_en || (mask[g] ^ pred_inv));
    end

    always_comb begin
        found = 1'b0;
        first = '0;
        for (int i = MAX_VL - 1; i >= 0; i--) begin
            if (act[i] && (VLW'(i) >= cursor)) begin
                found = 1'b1;
                first = EW'(i);
            end
        end
    end

endmodule

// File: rtl/sla_addr.sv
// Byte address of one field of one element.
module sla_addr #(
    parameter int AW     = 32,
    parameter int MAX_VL = 8,
    parameter int EW     = 3,
    parameter int SEGW   = 3
) (
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        stride_reg,
    input  logic [1:0]           esz,
    input  logic                 unit,
    input  logic                 idxv,
    input  logic [MAX_VL*AW-1:0] idx_flat,
    input  logic [SEGW-1:0]      seg,
    input  logic [EW-1:0]        elem,
    input  logic [SEGW-1:0]      field,
    output logic [AW-1:0]        addr
);

    logic [AW-1:0] idx_arr [MAX_VL];
    logic [AW-1:0] stride;
    logic [AW-1:0] nfields;
    logic [AW-1:0] lin_off;
    logic [AW-1:0] elem_off;

    for (genvar g = 0; g < MAX_VL; g++) begin : g_idx
        assign idx_arr[g] = idx_flat[g*AW +: AW];
    end

    always_comb begin
        stride   = unit ? AW'(sla_pkg::elem_bytes(esz)) : stride_reg;
        nfields  = AW'(seg) + AW'(1);
        lin_off  = AW'(elem) * nfields * stride;
        elem_off = idxv ? idx_arr[elem] : lin_off;
        addr     = base + elem_off + AW'(field) * stride;
    end

endmodule

// File: rtl/sla_ctrl.sv
// Sequencer: scan for active element, request each field, wait for data.
module sla_ctrl
    import sla_pkg::*;
#(
    parameter int VLW  = 4,
    parameter int EW   = 3,
    parameter int SEGW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VLW-1:0]  vl_in,
    input  logic            found,
    input  logic [EW-1:0]   first,
    input  logic [SEGW-1:0] seg,
    input  logic            req_ready,
    input  logic            rsp_valid,
    output logic [VLW-1:0]  cursor,
    output logic [EW-1:0]   elem,
    output logic [SEGW-1:0] field,
    output logic            latch_en,
    output logic            busy,
    output logic            req_valid,
    output logic            wr_en,
    output logic            done
);

    sla_state_e state_q;
    logic       done_q;

    assign latch_en  = (state_q == ST_IDLE) && start;
    assign busy      = (state_q != ST_IDLE);
    assign req_valid = (state_q == ST_REQ);
    assign wr_en     = (state_q == ST_WAIT) && rsp_valid;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cursor  <= '0;
            elem    <= '0;
            field   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cursor <= '0;
                        if (vl_in == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (found) begin
                        elem    <= first;
                        field   <= '0;
                        state_q <= ST_REQ;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (field == seg) begin
                            cursor  <= VLW'(elem) + VLW'(1);
                            state_q <= ST_SCAN;
                        end else begin
                            field   <= field + SEGW'(1);
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg_load_agen.sv
module seg_load_agen #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int MAX_VL = 8,
    parameter int SEGW   = 3,
    parameter int REGW   = 5,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int EW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [AW-1:0]        base_addr,
    input  logic [AW-1:0]        stride_val,
    input  logic [1:0]           elem_size,
    input  logic                 unit_stride,
    input  logic                 idx_vec,
    input  logic [MAX_VL*AW-1:0] idx_flat,
    input  logic [SEGW-1:0]      seglen,
    input  logic [VLW-1:0]       vl,
    input  logic [REGW-1:0]      rd,
    input  logic                 pred_en,
    input  logic                 pred_inv,
    input  logic [MAX_VL-1:0]    pred_mask,
    output logic                 busy,
    output logic                 done,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    input  logic                 rsp_valid,
    input  logic [DW-1:0]        rsp_data,
    output logic                 wr_en,
    output logic [REGW-1:0]      wr_reg,
    output logic [EW-1:0]        wr_elem,
    output logic [DW-1:0]        wr_data
);

    // configuration captured at the accepted start
    logic [AW-1:0]        base_q, stride_q;
    logic [1:0]           esz_q;
    logic                 unit_q, idxv_q, pe_q, inv_q;
    logic [MAX_VL*AW-1:0] idx_q;
    logic [SEGW-1:0]      seg_q;
    logic [VLW-1:0]       vl_q;
    logic [REGW-1:0]      rd_q;
    logic [MAX_VL-1:0]    mask_q;

    logic                 latch_en, found;
    logic [EW-1:0]        first, elem;
    logic [SEGW-1:0]      field;
    logic [VLW-1:0]       cursor;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            stride_q <= '0;
            esz_q    <= '0;
            unit_q   <= 1'b0;
            idxv_q   <= 1'b0;
            pe_q     <= 1'b0;
            inv_q    <= 1'b0;
            idx_q    <= '0;
            seg_q    <= '0;
            vl_q     <= '0;
            rd_q     <= '0;
            mask_q   <= '0;
        end else if (latch_en) begin
            base_q   <= base_addr;
            stride_q <= stride_val;
            esz_q    <= elem_size;
            unit_q   <= unit_stride;
            idxv_q   <= idx_vec;
            pe_q     <= pred_en;
            inv_q    <= pred_inv;
            idx_q    <= idx_flat;
            seg_q    <= seglen;
            vl_q     <= vl;
            rd_q     <= rd;
            mask_q   <= pred_mask;
        end
    end

    sla_active #(.MAX_VL(MAX_VL), .VLW(VLW), .EW(EW)) u_active (
        .mask     (mask_q),
        .pred_en  (pe_q),
        .pred_inv (inv_q),
        .vl       (vl_q),
        .cursor   (cursor),
        .found    (found),
        .first    (first)
    );

    sla_addr #(.AW(AW), .MAX_VL(MAX_VL), .EW(EW), .SEGW(SEGW)) u_addr (
        .base       (base_q),
        .stride_reg (stride_q),
        .esz        (esz_q),
        .unit       (unit_q),
        .idxv       (idxv_q),
        .idx_flat   (idx_q),
        .seg        (seg_q),
        .elem       (elem),
        .field      (field),
        .addr       (req_addr)
    );

    sla_ctrl #(.VLW(VLW), .EW(EW), .SEGW(SEGW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl_in     (vl),
        .found     (found),
        .first     (first),
        .seg       (seg_q),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .cursor    (cursor),
        .elem      (elem),
        .field     (field),
        .latch_en  (latch_en),
        .busy      (busy),
        .req_valid (req_valid),
        .wr_en     (wr_en),
        .done      (done)
    );

    assign wr_reg  = rd_q + REGW'(field);
    assign wr_elem = elem;
    assign wr_data = rsp_data;

endmodule

// File: rtl/sla_checker.sv
module sla_checker #(
    parameter int AW     = 32,
    parameter int MAX_VL = 8,
    parameter int SEGW   = 3,
    parameter int REGW   = 5,
    parameter int VLW    = 4,
    parameter int EW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              req_valid,
    input logic              req_ready,
    input logic [AW-1:0]     req_addr,
    input logic              rsp_valid,
    input logic              wr_en,
    input logic [REGW-1:0]   wr_reg,
    input logic [EW-1:0]     wr_elem,
    input logic [VLW-1:0]    vl_q,
    input logic [REGW-1:0]   rd_q,
    input logic [SEGW-1:0]   seg_q,
    input logic              pe_q,
    input logic              inv_q,
    input logic [MAX_VL-1:0] mask_q
);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    p_write_on_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rsp_valid);

    p_write_in_seg_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (REGW'(wr_reg - rd_q) <= REGW'(seg_q)));

    p_write_in_vl_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (VLW'(wr_elem) < vl_q));

    p_write_active_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pe_q) |-> (mask_q[wr_elem] ^ inv_q));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !req_valid));

endmodule

bind seg_load_agen sla_checker #(
    .AW(AW), .MAX_VL(MAX_VL), .SEGW(SEGW), .REGW(REGW), .VLW(VLW), .EW(EW)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .wr_en(wr_en), .wr_reg(wr_reg), .wr_elem(wr_elem),
    .vl_q(vl_q), .rd_q(rd_q), .seg_q(seg_q), .pe_q(pe_q), .inv_q(inv_q),
    .mask_q(mask_q)
);

// File: tb/seg_load_agen_tb.sv
`timescale 1ns/100ps
module seg_load_agen_tb;
    localparam int AW = 32, DW = 32, MAX_VL = 8, SEGW = 3, REGW = 5;
    localparam int VLW = 4, EW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0, stride_val = '0;
    logic [1:0] elem_size = '0;
    logic unit_stride = 1'b0, idx_vec = 1'b0, pred_en = 1'b0, pred_inv = 1'b0;
    logic [MAX_VL*AW-1:0] idx_flat = '0;
    logic [SEGW-1:0] seglen = '0;
    logic [VLW-1:0] vl = '0;
    logic [REGW-1:0] rd = '0;
    logic [MAX_VL-1:0] pred_mask = '0;
    logic busy, done, req_valid, req_addr_dummy;
    logic req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic wr_en;
    logic [REGW-1:0] wr_reg;
    logic [EW-1:0] wr_elem;
    logic [DW-1:0] wr_data;

    always #2.5 clk = ~clk;

    seg_load_agen u_dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .stride_val(stride_val), .elem_size(elem_size), .unit_stride(unit_stride),
        .idx_vec(idx_vec), .idx_flat(idx_flat), .seglen(seglen), .vl(vl), .rd(rd),
        .pred_en(pred_en), .pred_inv(pred_inv), .pred_mask(pred_mask),
        .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_elem(wr_elem), .wr_data(wr_data)
    );
    assign req_addr_dummy = 1'b0;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    logic [AW-1:0] exp_addr [64];
    logic [REGW-1:0] exp_reg [64];
    int exp_elem [64];
    int nexp = 0, nreq = 0, nwr = 0;
    int done_cnt = 0, done_cyc = 0;
    string tag_a = "R3";
    logic pend = 1'b0;
    int lat = 0;
    logic [AW-1:0] paddr = '0;

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        return (a * 32'd3) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model and sampler: drive at negedge, sample just before posedge
    always @(negedge clk) begin
        if (pend && lat == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = memval(paddr);
            pend      = 1'b0;
        end else begin
            rsp_valid = 1'b0;
            if (pend) lat = lat - 1;
        end
        req_ready = ((cyc % 4) != 1);
        #2;
        cyc++;
        if (!rst) begin
            if (req_valid && req_ready) begin
                if (nreq < nexp)
                    check(req_addr == exp_addr[nreq], tag_a, "request address",
                          64'(req_addr), 64'(exp_addr[nreq]));
                else
                    check(1'b0, "R8", "unexpected request", 64'(req_addr), 64'(0));
                paddr = req_addr;
                pend  = 1'b1;
                lat   = nreq % 3;
                nreq++;
            end
            if (wr_en) begin
                if (nwr < nexp) begin
                    check(wr_reg == exp_reg[nwr], "R5", "write register",
                          64'(wr_reg), 64'(exp_reg[nwr]));
                    check(int'(wr_elem) == exp_elem[nwr], "R5", "write element",
                          64'(wr_elem), 64'(exp_elem[nwr]));
                    check(wr_data == memval(exp_addr[nwr]), "R5", "write data",
                          64'(wr_data), 64'(memval(exp_addr[nwr])));
                end else begin
                    check(1'b0, "R8", "unexpected write", 64'(wr_elem), 64'(0));
                end
                nwr++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic run_case(input int mode, input int seg, input int esz,
                            input int pc, input int vlv, input int runid, input bit dbl);
        logic [AW-1:0] b, s, st, off;
        logic [MAX_VL-1:0] m;
        logic [REGW-1:0] r;
        int scyc, t;
        b = 32'h1000 + 32'(runid) * 32'h40;
        s = 32'h10 + 32'(seg) * 32'd4 + 32'(esz);
        m = 8'hB2 ^ 8'(runid);
        r = REGW'(3 + runid % 29);
        @(negedge clk);
        base_addr   = b;
        stride_val  = s;
        elem_size   = 2'(esz);
        unit_stride = (mode == 0);
        idx_vec     = (mode == 2);
        seglen      = SEGW'(seg);
        vl          = VLW'(vlv);
        rd          = r;
        pred_en     = (pc != 0);
        pred_inv    = (pc == 2);
        pred_mask   = m;
        for (int i = 0; i < MAX_VL; i++)
            idx_flat[i*AW +: AW] = 32'h200 + 32'(((i * 5 + runid) % 8) * 24);
        tag_a = (mode == 0) ? "R1/R3" : (mode == 1) ? "R2/R3" : "R4";
        // expected sequence
        st = (mode == 0) ? (32'd1 << esz) : s;
        nexp = 0;
        for (int e = 0; e < vlv; e++) begin
            if (pc == 0 || (m[e] ^ (pc == 2))) begin
                for (int j = 0; j <= seg; j++) begin
                    off = (mode == 2) ? idx_flat[e*AW +: AW]
                                      : 32'(e) * 32'(seg + 1) * st;
                    exp_addr[nexp] = b + off + 32'(j) * st;
                    exp_reg[nexp]  = r + REGW'(j);
                    exp_elem[nexp] = e;
                    nexp++;
                end
            end
        end
        nreq = 0; nwr = 0; done_cnt = 0;
        start = 1'b1;
        scyc  = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        base_addr = 32'hDEAD_0000;  // inputs after start must be ignored (R11)
        if (dbl && nexp >= 2) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt == 1, "R10", "done pulse seen", 64'(done_cnt), 64'(1));
        if (vlv == 0)
            check(done_cyc == scyc + 1, "R10", "done cycle for empty load",
                  64'(done_cyc), 64'(scyc + 1));
        check(nwr == nexp, (pc == 0) ? "R7" : "R6/R8", "write count",
              64'(nwr), 64'(nexp));
        repeat (4) @(negedge clk);
        check(nreq == nexp, dbl ? "R11" : "R9", "request count after done",
              64'(nreq), 64'(nexp));
        check(done_cnt == 1 && !busy, "R10", "single done and idle",
              64'(done_cnt), 64'(1));
    endtask

    initial begin
        #(200000 * 5);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int runid;
        int vls [3];
        vls[0] = 0; vls[1] = 3; vls[2] = 8;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(!busy && !done && !req_valid && !wr_en, "R11", "reset idle state",
              64'({busy, done, req_valid, wr_en}), 64'(0));
        runid = 0;
        for (int mode = 0; mode < 3; mode++)
            for (int seg = 0; seg < 3; seg++)
                for (int esz = 0; esz < 4; esz++)
                    for (int pc = 0; pc < 3; pc++)
                        for (int k = 0; k < 3; k++) begin
                            run_case(mode, seg, esz, pc, vls[k], runid, (runid % 5) == 0);
                            runid++;
                        end
        // full-length, all-masked and single-element corners
        run_case(2, 7, 1, 1, 8, 7, 1'b1);
        run_case(1, 0, 0, 1, 8, 8'hB2, 1'b0);   // mask ^ id = 0: nothing active
        run_case(0, 1, 3, 0, 1, 300, 1'b0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule